// File: doc/BRIEF.md
# Task Switch Permission Checker

This block judges a single request to move execution to another task. It takes the cause of the switch, the current privilege level, the selector used to name the target, and the decoded fields of the descriptor that selector reaches. When that descriptor is a task gate, it also takes the selector held in the gate and the decoded fields of the task-state descriptor the gate points to. One clock after a request it reports whether the switch may go ahead. If it may not, it reports a fault class and the selector that the fault handler must see.

Fetching descriptors from memory, saving and loading task state, and updating busy flags all happen elsewhere. This block only decides. The result is a single registered word, so the sequencer that drives it can issue one request per cycle.

Top module: `tsw_perm_check`

## Requirements
- R1: Every request with `req_valid` high produces a response with `rsp_valid` high exactly one clock later. With no request, `rsp_valid` is low in the next cycle. Reset clears `rsp_valid` and `rsp_ok`.
- R2: `rsp_fault` uses the codes 0 = none, 1 = not-present, 2 = general protection, 3 = invalid task state. On a response, `rsp_ok` is high exactly when `rsp_fault` is 0.
- R3: In a direct request (no gate), bit 2 of `req_sel` marks a selector into the local table. When it is set, the result is a general-protection fault naming `req_sel`. This test comes before the privilege, present, busy and limit tests.
- R4: For a jump (cause 0) or a call (cause 1), the switch is refused with a general-protection fault naming `req_sel` when the target DPL is below the larger of `cur_cpl` and `req_sel[1:0]`. An interrupt (cause 2) or a return (cause 3) skips this test.
- R5: A target with `tgt_sys`=0 and `tgt_type`=4'b0101 is a task gate, and the privilege test of R4 uses the gate's DPL. These gate faults name `req_sel`: a return through a gate (general protection), a refused privilege test (general protection) and a gate that is not present (not-present). After those, a set bit 2 of `gate_sel` or an inner descriptor that is not a task-state type gives a general-protection fault naming `gate_sel`.
- R6: A task-state descriptor whose present bit is clear gives a not-present fault naming that descriptor's selector.
- R7: A task-state descriptor has type 4'b1001 when idle and 4'b1011 when busy (bit 1 is the busy flag). A jump, call or interrupt to a busy task gives a general-protection fault. A return to an idle task gives a general-protection fault.
- R8: The effective limit is the 20-bit limit when the granularity bit is clear. When the bit is set, it is the limit shifted left by 12 with twelve 1 bits filled in below. An effective limit below 103 gives an invalid-task-state fault.
- R9: When more than one task-state test fails, the present test wins, then the busy test, then the limit test.
- R10: A direct target that is neither a task-state descriptor nor a task gate (including any `tgt_sys`=1 descriptor) gives a general-protection fault naming `req_sel`.
- R11: A passing switch reports the selector of the incoming task-state descriptor in `rsp_sel`. That is `req_sel` for a direct switch and `gate_sel` (with its RPL bits unchanged and unused) for a gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cause | input | 2 | 0 jump, 1 call, 2 interrupt/exception, 3 return |
| cur_cpl | input | 2 | Current privilege level |
| req_sel | input | SEL_W | Requesting selector; [1:0] RPL, [2] local-table flag |
| tgt_sys | input | 1 | Target segment flag; 0 means system descriptor |
| tgt_type | input | 4 | Target type field |
| tgt_dpl | input | 2 | Target DPL |
| tgt_present | input | 1 | Target present bit |
| tgt_limit | input | LIMIT_W | Target raw limit |
| tgt_gran | input | 1 | Target granularity bit |
| gate_sel | input | SEL_W | Selector held in a task gate |
| inr_sys | input | 1 | Gate-referenced descriptor segment flag |
| inr_type | input | 4 | Gate-referenced descriptor type |
| inr_present | input | 1 | Gate-referenced descriptor present bit |
| inr_limit | input | LIMIT_W | Gate-referenced descriptor raw limit |
| inr_gran | input | 1 | Gate-referenced descriptor granularity bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Switch allowed |
| rsp_fault | output | 2 | Fault class |
| rsp_sel | output | SEL_W | Selector to report or load |

## Verification
The bench builds the block with its default parameters: 16-bit selectors, 20-bit limits, a 12-bit page shift and a minimum limit of 103. With these values, the exact boundary at 102 and 103 can be reached directly. So can the case where setting the granularity bit lifts a zero limit to 4095. Random raw limits are drawn half the time from the range below 200, so both sides of the minimum occur often. Gate and task-state type codes are favoured in the random mix, so the gate path and the checks on the inner descriptor are exercised heavily.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [1:0] {
        CAUSE_JMP  = 2'd0,
        CAUSE_CALL = 2'd1,
        CAUSE_INT  = 2'd2,
        CAUSE_IRET = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_NP   = 2'd1,
        FLT_GP   = 2'd2,
        FLT_TS   = 2'd3
    } fault_e;

    localparam logic [3:0] TYPE_GATE = 4'b0101;
    localparam int         TI_BIT    = 2;

endpackage

// File: rtl/tsw_priv_check.sv
module tsw_priv_check
    import tsw_pkg::*;
(
    input  logic [1:0] cause,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic [1:0] dpl,
    output logic       deny
);
    logic [1:0] eff_lvl;
    logic       sw_cause;

    always_comb begin
        eff_lvl  = (cpl > rpl) ? cpl : rpl;
        sw_cause = (cause_e'(cause) == CAUSE_JMP) || (cause_e'(cause) == CAUSE_CALL);
        deny     = sw_cause && (dpl < eff_lvl);
    end
endmodule

// File: rtl/tsw_tss_check.sv
module tsw_tss_check #(
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int MIN_LIMIT  = 103
) (
    input  logic               sys_flag,
    input  logic [3:0]         typ,
    input  logic               present,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               gran,
    input  logic               need_busy,
    output logic               is_tss,
    output logic               np_fail,
    output logic               busy_fail,
    output logic               lim_fail
);
    localparam int EFF_W = LIMIT_W + PAGE_SHIFT;

    logic [EFF_W-1:0] eff_limit;

    always_comb begin
        eff_limit = gran ? {limit, {PAGE_SHIFT{1'b1}}}
                         : {{PAGE_SHIFT{1'b0}}, limit};
        is_tss    = !sys_flag && (typ[3:2] == 2'b10) && typ[0];
        np_fail   = !present;
        busy_fail = need_busy ? !typ[1] : typ[1];
        lim_fail  = eff_limit < EFF_W'(MIN_LIMIT);
    end
endmodule

// File: rtl/tsw_perm_check.sv
module tsw_perm_check
    import tsw_pkg::*;
#(
    parameter int SEL_W      = 16,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int MIN_LIMIT  = 103
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_cause,
    input  logic [1:0]         cur_cpl,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               tgt_sys,
    input  logic [3:0]         tgt_type,
    input  logic [1:0]         tgt_dpl,
    input  logic               tgt_present,
    input  logic [LIMIT_W-1:0] tgt_limit,
    input  logic               tgt_gran,
    input  logic [SEL_W-1:0]   gate_sel,
    input  logic               inr_sys,
    input  logic [3:0]         inr_type,
    input  logic               inr_present,
    input  logic [LIMIT_W-1:0] inr_limit,
    input  logic               inr_gran,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [1:0]         rsp_fault,
    output logic [SEL_W-1:0]   rsp_sel
);
    localparam int NVIEW = 2;   // 0: direct target, 1: descriptor behind a gate

    typedef struct packed {
        logic             valid;
        logic             ok;
        fault_e           fault;
        logic [SEL_W-1:0] sel;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic                need_busy;
    logic                priv_deny;
    logic                is_gate;
    logic                v_sys     [NVIEW];
    logic [3:0]          v_type    [NVIEW];
    logic                v_present [NVIEW];
    logic [LIMIT_W-1:0]  v_limit   [NVIEW];
    logic                v_gran    [NVIEW];
    logic                v_is_tss  [NVIEW];
    logic                v_np      [NVIEW];
    logic                v_busy    [NVIEW];
    logic                v_lim     [NVIEW];

    assign need_busy = (cause_e'(req_cause) == CAUSE_IRET);
    assign is_gate   = !tgt_sys && (tgt_type == TYPE_GATE);

    assign v_sys[0] = tgt_sys;      assign v_sys[1] = inr_sys;
    assign v_type[0] = tgt_type;    assign v_type[1] = inr_type;
    assign v_present[0] = tgt_present; assign v_present[1] = inr_present;
    assign v_limit[0] = tgt_limit;  assign v_limit[1] = inr_limit;
    assign v_gran[0] = tgt_gran;    assign v_gran[1] = inr_gran;

    tsw_priv_check u_priv (
        .cause (req_cause),
        .cpl   (cur_cpl),
        .rpl   (req_sel[1:0]),
        .dpl   (tgt_dpl),
        .deny  (priv_deny)
    );

    for (genvar gv = 0; gv < NVIEW; gv++) begin : g_view
        tsw_tss_check #(
            .LIMIT_W    (LIMIT_W),
            .PAGE_SHIFT (PAGE_SHIFT),
            .MIN_LIMIT  (MIN_LIMIT)
        ) u_tss (
            .sys_flag  (v_sys[gv]),
            .typ       (v_type[gv]),
            .present   (v_present[gv]),
            .limit     (v_limit[gv]),
            .gran      (v_gran[gv]),
            .need_busy (need_busy),
            .is_tss    (v_is_tss[gv]),
            .np_fail   (v_np[gv]),
            .busy_fail (v_busy[gv]),
            .lim_fail  (v_lim[gv])
        );
    end

    always_comb begin
        int unsigned vi;
        rsp_d       = '0;
        rsp_d.fault = FLT_NONE;
        vi          = is_gate ? 1 : 0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.sel   = is_gate ? gate_sel : req_sel;
            // stages that belong to the gate or the direct selector
            if (is_gate) begin
                if (need_busy) begin
                    rsp_d.fault = FLT_GP;
                    rsp_d.sel   = req_sel;
                end else if (priv_deny) begin
                    rsp_d.fault = FLT_GP;
                    rsp_d.sel   = req_sel;
                end else if (!tgt_present) begin
                    rsp_d.fault = FLT_NP;
                    rsp_d.sel   = req_sel;
                end else if (gate_sel[TI_BIT] || !v_is_tss[1]) begin
                    rsp_d.fault = FLT_GP;
                end
            end else if (!v_is_tss[0] || req_sel[TI_BIT] || priv_deny) begin
                rsp_d.fault = FLT_GP;
            end
            // task-state tests, in fixed priority order
            if (rsp_d.fault == FLT_NONE) begin
                if (v_np[vi])
                    rsp_d.fault = FLT_NP;
                else if (v_busy[vi])
                    rsp_d.fault = FLT_GP;
                else if (v_lim[vi])
                    rsp_d.fault = FLT_TS;
            end
            rsp_d.ok = (rsp_d.fault == FLT_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_ok    = rsp_q.ok;
    assign rsp_fault = rsp_q.fault;
    assign rsp_sel   = rsp_q.sel;
endmodule

// File: rtl/tsw_perm_check_sva.sv
module tsw_perm_check_sva #(
    parameter int SEL_W   = 16,
    parameter int LIMIT_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_cause,
    input logic [1:0]         cur_cpl,
    input logic [SEL_W-1:0]   req_sel,
    input logic               tgt_sys,
    input logic [3:0]         tgt_type,
    input logic [1:0]         tgt_dpl,
    input logic               tgt_present,
    input logic [LIMIT_W-1:0] tgt_limit,
    input logic               tgt_gran,
    input logic [SEL_W-1:0]   gate_sel,
    input logic               inr_sys,
    input logic [3:0]         inr_type,
    input logic               inr_present,
    input logic [LIMIT_W-1:0] inr_limit,
    input logic               inr_gran,
    input logic               rsp_valid,
    input logic               rsp_ok,
    input logic [1:0]         rsp_fault,
    input logic [SEL_W-1:0]   rsp_sel
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1

    AST_OK_IFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ok == (rsp_fault == 2'd0))); // R2

    AST_LOCAL_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tgt_sys && tgt_type == 4'b1001 && req_sel[2])
        |=> (rsp_fault == 2'd2 && rsp_sel == $past(req_sel))); // R3

    AST_INT_SKIPS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 2'd2 && !tgt_sys && tgt_type == 4'b1001
         && tgt_present && tgt_gran && !req_sel[2])
        |=> rsp_ok); // R4

    AST_ABSENT_TSS_NP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause[1] && !tgt_sys && tgt_type[3:2] == 2'b10
         && tgt_type[0] && !req_sel[2] && !tgt_present)
        |=> (rsp_fault == 2'd1 && rsp_sel == $past(req_sel))); // R6

    AST_IRET_IDLE_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 2'd3 && !tgt_sys && tgt_type == 4'b1001
         && tgt_present && !req_sel[2])
        |=> (rsp_fault == 2'd2)); // R7

    AST_SEG_TARGET_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tgt_sys) |=> (rsp_fault == 2'd2)); // R10
endmodule

bind tsw_perm_check tsw_perm_check_sva #(.SEL_W(SEL_W), .LIMIT_W(LIMIT_W)) u_sva (.*);

// File: tb/tsw_perm_check_test.sv
module tsw_perm_check_test;
    localparam int SEL_W   = 16;
    localparam int LIMIT_W = 20;
    localparam logic [1:0] C_JMP = 2'd0, C_CALL = 2'd1, C_INT = 2'd2, C_IRET = 2'd3;
    localparam logic [1:0] F_NONE = 2'd0, F_NP = 2'd1, F_GP = 2'd2, F_TS = 2'd3;
    localparam logic [3:0] T_IDLE = 4'b1001, T_BUSY = 4'b1011, T_GATE = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_cause = '0, cur_cpl = '0, tgt_dpl = '0;
    logic [SEL_W-1:0] req_sel = '0, gate_sel = '0;
    logic tgt_sys = 1'b0, tgt_present = 1'b0, tgt_gran = 1'b0;
    logic inr_sys = 1'b0, inr_present = 1'b0, inr_gran = 1'b0;
    logic [3:0] tgt_type = '0, inr_type = '0;
    logic [LIMIT_W-1:0] tgt_limit = '0, inr_limit = '0;
    logic rsp_valid, rsp_ok;
    logic [1:0] rsp_fault;
    logic [SEL_W-1:0] rsp_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tsw_perm_check uut (.*);

    function automatic logic [18:0] pack_res(input logic [1:0] f, input logic [SEL_W-1:0] s);
        return {f == F_NONE, f, s};
    endfunction

    function automatic logic [18:0] tss_tests(input logic [1:0] cause, input logic pres,
            input logic [3:0] typ, input logic [LIMIT_W-1:0] lim, input logic gran,
            input logic [SEL_W-1:0] s);
        longint eff;
        eff = gran ? ((longint'(lim) << 12) + 4095) : longint'(lim);
        if (!pres) return pack_res(F_NP, s);
        if (cause == C_IRET ? !typ[1] : typ[1]) return pack_res(F_GP, s);
        if (eff < 103) return pack_res(F_TS, s);
        return pack_res(F_NONE, s);
    endfunction

    function automatic logic [18:0] expect_res();
        logic [1:0] lvl;
        logic deny, gate, tss, itss;
        lvl  = (cur_cpl > req_sel[1:0]) ? cur_cpl : req_sel[1:0];
        deny = (req_cause == C_JMP || req_cause == C_CALL) && (tgt_dpl < lvl);
        gate = !tgt_sys && tgt_type == T_GATE;
        tss  = !tgt_sys && (tgt_type == T_IDLE || tgt_type == T_BUSY);
        itss = !inr_sys && (inr_type == T_IDLE || inr_type == T_BUSY);
        if (gate) begin
            if (req_cause == C_IRET) return pack_res(F_GP, req_sel);
            if (deny) return pack_res(F_GP, req_sel);
            if (!tgt_present) return pack_res(F_NP, req_sel);
            if (gate_sel[2] || !itss) return pack_res(F_GP, gate_sel);
            return tss_tests(req_cause, inr_present, inr_type, inr_limit, inr_gran, gate_sel);
        end
        if (!tss || req_sel[2] || deny) return pack_res(F_GP, req_sel);
        return tss_tests(req_cause, tgt_present, tgt_type, tgt_limit, tgt_gran, req_sel);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_tgt(input logic [3:0] t, input logic [1:0] d, input logic p,
                           input logic [LIMIT_W-1:0] l, input logic g);
        tgt_sys = 1'b0; tgt_type = t; tgt_dpl = d; tgt_present = p; tgt_limit = l; tgt_gran = g;
    endtask

    task automatic set_inr(input logic [3:0] t, input logic p,
                           input logic [LIMIT_W-1:0] l, input logic g);
        inr_sys = 1'b0; inr_type = t; inr_present = p; inr_limit = l; inr_gran = g;
    endtask

    // called at a falling edge with all fields set
    task automatic issue(input string tag);
        logic [18:0] exp;
        exp = expect_res();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 valid", 32'(rsp_valid), 32'd1);
        check("R2 ok/fault", 32'(rsp_ok), 32'(rsp_fault == F_NONE));
        check(tag, {13'd0, rsp_ok, rsp_fault, rsp_sel}, {13'd0, exp});
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(rsp_valid), 32'd0);
        check("R1 reset ok", 32'(rsp_ok), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 32'(rsp_valid), 32'd0);

        // direct jump to idle task, pass: R11
        req_cause = C_JMP; cur_cpl = 0; req_sel = 16'h0028; set_tgt(T_IDLE, 0, 1, 103, 0);
        issue("R11 direct pass");
        // local-table flag set: R3
        req_sel = 16'h002C; issue("R3 local selector");
        // privilege refused for call, skipped for interrupt: R4
        req_cause = C_CALL; cur_cpl = 2; req_sel = 16'h0030; set_tgt(T_IDLE, 1, 1, 200, 0);
        issue("R4 call denied");
        req_sel = 16'h0033; cur_cpl = 0; issue("R4 rpl denies");
        req_cause = C_INT; cur_cpl = 3; issue("R4 interrupt skips");
        // priority: R9
        req_cause = C_JMP; cur_cpl = 0; req_sel = 16'h0040; set_tgt(T_BUSY, 0, 0, 5, 0);
        issue("R9 absent wins");
        set_tgt(T_BUSY, 0, 1, 5, 0); issue("R9 busy before limit");
        // not present: R6
        set_tgt(T_IDLE, 0, 0, 500, 0); issue("R6 not present");
        // limit boundary and granularity: R8
        set_tgt(T_IDLE, 0, 1, 102, 0); issue("R8 limit 102");
        set_tgt(T_IDLE, 0, 1, 103, 0); issue("R8 limit 103");
        set_tgt(T_IDLE, 0, 1, 0, 1);   issue("R8 granular zero");
        // busy rules: R7
        req_cause = C_IRET; set_tgt(T_BUSY, 0, 1, 300, 0); issue("R7 return busy ok");
        set_tgt(T_IDLE, 0, 1, 300, 0); issue("R7 return idle");
        req_cause = C_CALL; set_tgt(T_BUSY, 0, 1, 300, 0); issue("R7 call busy");
        // gates: R5
        req_cause = C_JMP; cur_cpl = 3; req_sel = 16'h0107; gate_sel = 16'h0053;
        set_tgt(T_GATE, 3, 1, 0, 0); set_inr(T_IDLE, 1, 104, 0);
        issue("R5 gate pass uses gate sel");
        tgt_dpl = 0; issue("R5 gate dpl denies");
        req_cause = C_INT; issue("R5 interrupt through gate");
        gate_sel = 16'h0054; issue("R5 inner local selector");
        gate_sel = 16'h0050; inr_type = 4'b0010; issue("R5 inner not task state");
        inr_type = T_IDLE; tgt_present = 1'b0; issue("R5 gate absent");
        tgt_present = 1'b1; req_cause = C_IRET; issue("R5 return through gate");
        req_cause = C_INT; inr_limit = 50; issue("R5 inner limit");
        // non-task target: R10
        req_cause = C_JMP; cur_cpl = 0; req_sel = 16'h0060; set_tgt(T_IDLE, 3, 1, 300, 0);
        tgt_sys = 1'b1; issue("R10 segment target");
        tgt_sys = 1'b0; tgt_type = 4'b0010; issue("R10 wrong system type");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] pick;
            req_cause = 2'($urandom); cur_cpl = 2'($urandom);
            req_sel = 16'($urandom); gate_sel = 16'($urandom);
            if ($urandom % 4 != 0) req_sel[2] = 1'b0;
            if ($urandom % 4 != 0) gate_sel[2] = 1'b0;
            pick = 4'($urandom % 8);
            tgt_type = (pick < 3) ? T_GATE : (pick < 5) ? T_IDLE : (pick < 7) ? T_BUSY : 4'($urandom);
            inr_type = (pick[0]) ? T_IDLE : (pick[1]) ? T_BUSY : 4'($urandom);
            tgt_sys = ($urandom % 8 == 0); inr_sys = ($urandom % 8 == 0);
            tgt_dpl = 2'($urandom);
            tgt_present = ($urandom % 8 != 0); inr_present = ($urandom % 8 != 0);
            tgt_limit = ($urandom % 2) ? LIMIT_W'($urandom % 200) : LIMIT_W'($urandom);
            inr_limit = ($urandom % 2) ? LIMIT_W'($urandom % 200) : LIMIT_W'($urandom);
            tgt_gran = ($urandom % 4 == 0); inr_gran = ($urandom % 4 == 0);
            issue("R9 random mix");
            if (i % 7 == 0) begin
                @(negedge clk);
                check("R1 gap", 32'(rsp_valid), 32'd0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule